// File: doc/BRIEF.md
# Two-Wire Bus Bit-Rate Divider

This block turns the core clock into the timing pulses that a two-wire serial master uses to move its clock line and to sample the data line. One 8-bit configuration word holds two factors. A linear prescaler divides the core clock by (M+1). Its output steps a power-of-two stage that divides by 2^(N+1) and produces a one-cycle sample tick. A phase counter groups ten sample ticks into one bus bit period. Within that period it marks four quarter points, so the serial clock runs at f_core / (10 × (M+1) × 2^(N+1)).

A small controller holds the dividers. It has three states. `RS_OFF` is entered whenever enable is low. `RS_SYNC` lasts one cycle: the cycle after enable rises or after any configuration write. `RS_RUN` is entered from `RS_SYNC` and stays there. In every state other than `RS_RUN`, and in any cycle that carries a write, all counters and outputs are cleared. A new rate therefore always starts from a clean phase. The byte engine that sits downstream uses the quarter strobes and their index to drive and sample the bus.

Top module: `twr_rate_divider`

## Requirements
- R1: The N factor is taken from cfg_data bits [2:0] and the M factor from bits [6:3]. Bit 7 has no effect on the timing.
- R2: Successive sample_tick pulses are exactly (M+1) × 2^(N+1) core cycles apart. Each pulse lasts one cycle.
- R3: With M=0 and N=0, sample_tick repeats every 2 cycles, so one bit period is 20 cycles.
- R4: With M=15 and N=7, sample_tick repeats every 4096 cycles.
- R5: Sample ticks are numbered 0 to 9 within each bit period, and the numbering wraps after 9. phase_stb is high on ticks 0, 3, 5 and 8. On those ticks phase_num reads 0, 1, 2 and 3 in that order.
- R6: phase_stb is never high in a cycle where sample_tick is low.
- R7: A write (cfg_wr high at a rising edge) clears both dividers and the phase count. No tick follows that edge until the first new tick, which appears after the (D+1)-th edge counted from the write edge, where D is the new period. That first new tick has index 0.
- R8: While enable is low, sample_tick and phase_stb stay low. After enable is seen high at an edge, the first tick follows D+1 edges later, with index 0.
- R9: While rst_n is low, sample_tick, phase_stb and phase_num are 0, and the controller is in RS_OFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Controller enable; low holds all counters cleared |
| cfg_wr | input | 1 | Write strobe for the rate word |
| cfg_data | input | 8 | Rate word: [2:0] N, [6:3] M, [7] unused |
| sample_tick | output | 1 | One-cycle pulse every (M+1)·2^(N+1) cycles |
| phase_stb | output | 1 | Quarter-point strobe on ticks 0, 3, 5, 8 of a bit |
| phase_num | output | 2 | Index of the quarter point that phase_stb marks |

## Verification
The divider is tried with both extreme factor pairs, with a pair that has bit 7 set, and with seeded random pairs. Together these separate an error in the linear stage (a wrong M offset) from an error in the power-of-two stage (a wrong N shift). The delay from a write or an enable to the first tick is measured, which shows whether both stages really restart from zero. Running eleven ticks per pair checks the quarter-point pattern and its wrap back to index 0. A disabled window shows that no pulses leak out while enable is low.

// File: rtl/twr_rate_pkg.sv
package twr_rate_pkg;
    typedef enum logic [1:0] {
        RS_OFF  = 2'd0,
        RS_SYNC = 2'd1,
        RS_RUN  = 2'd2
    } rate_state_e;

    // Tick index of quarter point q in a bit of 'ticks' ticks (rounded half up)
    function automatic int quarter_pos(input int q, input int ticks);
        return (q * ticks + 2) / 4;
    endfunction
endpackage

// File: rtl/twr_prescale.sv
module twr_prescale #(
    parameter int M_W = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           run,
    input  logic [M_W-1:0] m_val,
    output logic           pulse
);
    logic [M_W-1:0] cnt;

    assign pulse = run && (cnt == m_val);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (run)
            cnt <= pulse ? '0 : cnt + 1'b1;
    end

    // R2: linear stage never counts past its terminal value
    p_pre_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= m_val)
        else $error("prescale count above M");
endmodule

// File: rtl/twr_pow2.sv
module twr_pow2 #(
    parameter int N_W = 3,
    localparam int CW = 2 ** N_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           step,
    input  logic [N_W-1:0] n_val,
    output logic           tick
);
    logic [CW-1:0] cnt;
    logic [CW-1:0] last;

    // terminal value 2^(N+1)-1
    assign last = {CW{1'b1}} >> (N_W'(CW - 1) - n_val);
    assign tick = step && (cnt == last);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt <= '0;
        else if (clr)
            cnt <= '0;
        else if (step)
            cnt <= tick ? '0 : cnt + 1'b1;
    end

    // R2: power-of-two stage stays below 2^(N+1)
    p_pow_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= last)
        else $error("pow2 count above limit");
endmodule

// File: rtl/twr_phase.sv
module twr_phase
    import twr_rate_pkg::*;
#(
    parameter int TICKS = 10,
    localparam int PW = $clog2(TICKS)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clr,
    input  logic       tick,
    output logic       samp_q,
    output logic       stb_q,
    output logic [1:0] num_q
);
    logic [PW-1:0] pcnt;
    logic [3:0]    hit;
    logic [1:0]    num;

    for (genvar q = 0; q < 4; q++) begin : g_quarter
        assign hit[q] = (pcnt == PW'(quarter_pos(q, TICKS)));
    end

    always_comb begin
        num = 2'd0;
        for (int q = 0; q < 4; q++)
            if (hit[q]) num = 2'(q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pcnt   <= '0;
            samp_q <= 1'b0;
            stb_q  <= 1'b0;
            num_q  <= 2'd0;
        end else if (clr) begin
            pcnt   <= '0;
            samp_q <= 1'b0;
            stb_q  <= 1'b0;
            num_q  <= 2'd0;
        end else begin
            samp_q <= tick;
            stb_q  <= tick && (|hit);
            if (tick && (|hit))
                num_q <= num;
            if (tick)
                pcnt <= (pcnt == PW'(TICKS - 1)) ? '0 : pcnt + 1'b1;
        end
    end

    // R5: tick index stays within one bit period
    p_pcnt_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pcnt <= PW'(TICKS - 1))
        else $error("phase count out of range");

    // R6: a quarter strobe only rides on a sample tick
    p_stb_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stb_q |-> samp_q)
        else $error("strobe without tick");
endmodule

// File: rtl/twr_rate_divider.sv
module twr_rate_divider
    import twr_rate_pkg::*;
#(
    parameter int M_W   = 4,
    parameter int N_W   = 3,
    parameter int TICKS = 10,
    localparam int CFG_W = M_W + N_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             cfg_wr,
    input  logic [CFG_W-1:0] cfg_data,
    output logic             sample_tick,
    output logic             phase_stb,
    output logic [1:0]       phase_num
);
    rate_state_e    state_q, state_d;
    logic [M_W-1:0] m_q;
    logic [N_W-1:0] n_q;
    logic           run, clr, pre_pulse, pow_tick;

    // rate word register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_q <= '0;
            n_q <= '0;
        end else if (cfg_wr) begin
            m_q <= cfg_data[N_W +: M_W];
            n_q <= cfg_data[N_W-1:0];
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RS_OFF:  if (enable) state_d = RS_SYNC;
            RS_SYNC: state_d = RS_RUN;
            RS_RUN:  state_d = RS_RUN;
            default: state_d = RS_OFF;
        endcase
        if (!enable)
            state_d = RS_OFF;
        else if (cfg_wr)
            state_d = RS_SYNC;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= RS_OFF;
        else
            state_q <= state_d;
    end

    // state outputs
    always_comb begin
        run = (state_q == RS_RUN);
        clr = !run || cfg_wr || !enable;
    end

    twr_prescale #(.M_W(M_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .clr(clr), .run(run),
        .m_val(m_q), .pulse(pre_pulse)
    );

    twr_pow2 #(.N_W(N_W)) u_pow (
        .clk(clk), .rst_n(rst_n), .clr(clr), .step(pre_pulse),
        .n_val(n_q), .tick(pow_tick)
    );

    twr_phase #(.TICKS(TICKS)) u_phase (
        .clk(clk), .rst_n(rst_n), .clr(clr), .tick(pow_tick),
        .samp_q(sample_tick), .stb_q(phase_stb), .num_q(phase_num)
    );

    // R7: the edge carrying a write leaves no tick behind
    p_wr_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !sample_tick)
        else $error("tick after write edge");

    // R7: sync lasts exactly one cycle when undisturbed
    p_sync_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == RS_SYNC && enable && !cfg_wr) |=> (state_q == RS_RUN))
        else $error("sync did not advance");

    // R8: disabled means silent
    p_off_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (!sample_tick && !phase_stb && state_q == RS_OFF))
        else $error("activity while disabled");
endmodule

// File: tb/twr_rate_divider_tb.sv
module twr_rate_divider_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       enable = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] cfg_data = 8'd0;
    logic       sample_tick, phase_stb;
    logic [1:0] phase_num;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    twr_rate_divider u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cfg_wr(cfg_wr),
        .cfg_data(cfg_data), .sample_tick(sample_tick),
        .phase_stb(phase_stb), .phase_num(phase_num)
    );

    function automatic int exp_period(input int m, input int n);
        return (m + 1) * (2 << n);
    endfunction

    function automatic bit exp_stb(input int i);
        int r = i % 10;
        return (r == 0) || (r == 3) || (r == 5) || (r == 8);
    endfunction

    function automatic int exp_num(input int i);
        int r = i % 10;
        return (r == 0) ? 0 : (r == 3) ? 1 : (r == 5) ? 2 : 3;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Called at the negedge right after the restart edge (edge index 0).
    task automatic measure(input int m, input int n, input int nt, input string tag);
        int d = exp_period(m, n);
        int k = 0;
        int got = 0;
        chk(sample_tick == 1'b0, "R7 quiet at restart edge", int'(sample_tick), 0);
        while (got < nt && k < d * nt + d + 5) begin
            @(posedge clk);
            k++;
            @(negedge clk);
            if (phase_stb && !sample_tick)
                chk(1'b0, "R6 strobe without tick", int'(phase_stb), 0);
            if (sample_tick) begin
                chk(k == d + 1 + got * d, tag, k, d + 1 + got * d);
                chk(phase_stb == exp_stb(got), "R5 strobe pattern",
                    int'(phase_stb), int'(exp_stb(got)));
                if (phase_stb)
                    chk(int'(phase_num) == exp_num(got), "R5 quarter index",
                        int'(phase_num), exp_num(got));
                got++;
            end
        end
        chk(got == nt, "R2 tick count", got, nt);
    endtask

    task automatic do_write(input logic [7:0] v);
        @(negedge clk);
        cfg_wr = 1'b1;
        cfg_data = v;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        int rv;
        rv = $urandom(32'd7261);
        // R9: reset state
        repeat (3) @(negedge clk);
        chk(sample_tick == 0, "R9 reset sample_tick", int'(sample_tick), 0);
        chk(phase_stb == 0, "R9 reset phase_stb", int'(phase_stb), 0);
        chk(phase_num == 0, "R9 reset phase_num", int'(phase_num), 0);
        rst_n = 1'b1;
        enable = 1'b1;
        repeat (5) @(negedge clk);

        // R3: fastest
        do_write({1'b0, 4'd0, 3'd0});
        measure(0, 0, 11, "R3 fastest period");
        // R1: bit 7 ignored, M/N field positions
        do_write({1'b1, 4'd5, 3'd1});
        measure(5, 1, 11, "R1 field decode bit7 set");
        // R7: write mid-run restarts cleanly
        repeat (7) @(negedge clk);
        do_write({1'b0, 4'd2, 3'd3});
        measure(2, 3, 11, "R7 restart after write");

        // random pairs
        for (int t = 0; t < 8; t++) begin
            int m, n;
            do begin
                m = int'($urandom % 16);
                n = int'($urandom % 8);
            end while (exp_period(m, n) > 512);
            do_write({1'(t), 4'(m), 3'(n)});
            measure(m, n, 11, "R2 random period");
        end

        // R8: disable window then re-enable latency
        do_write({1'b0, 4'd1, 3'd2});
        measure(1, 2, 3, "R2 pre-disable");
        @(negedge clk);
        enable = 1'b0;
        begin
            int seen = 0;
            for (int c = 0; c < 60; c++) begin
                @(negedge clk);
                if (sample_tick || phase_stb) seen++;
            end
            chk(seen == 0, "R8 quiet while disabled", seen, 0);
        end
        enable = 1'b1;
        @(posedge clk);
        @(negedge clk);
        measure(1, 2, 11, "R8 re-enable latency");

        // R4: slowest
        do_write({1'b0, 4'd15, 3'd7});
        measure(15, 7, 2, "R4 slowest period");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule